// File: doc/BRIEF.md
# Receive DC Offset Range Calibrator

This block chooses a coarse range setting for the offset-correction DAC of each of three receive chains. It first runs one calibration with offset correction switched off. After that it runs calibration passes. In each pass it requests a DC-offset calibration from an external engine and waits for the engine to finish. It then steps the shared gain-mode field through three settings, one clock cycle each, and records whether any of the I or Q residual offsets reported by the analog front end fall outside an accepted window.

A chain is finished when it passes a whole pass, or when it fails while already at the top range. A chain that fails below the top range moves up by one range and is tried again in the next pass. Passes continue until every chain is finished. The search for each chain starts from the range value supplied on its preload input when the start request is accepted. If the engine stays busy longer than a timeout, either in the preliminary run or in any pass, the whole operation ends with a fail pulse.

Top module: `rx_dco_range_cal`

## Requirements
- R1: When a start is accepted, each chain's 2-bit range is loaded from `range_init`, with chain c at bits [2c+1:2c]. After completion, `range_out` keeps its final values unchanged until the next accepted start, and changes on `range_init` while idle have no effect on it.
- R2: Calibration requests are one-cycle pulses on `cal_req`. Exactly one request (the preliminary one) is issued with `ofs_cal_en` low. Every later request in the same operation is issued with `ofs_cal_en` high.
- R3: After each pass's calibration completes, `gain_mode` presents code 1 (high gain), then 2 (low gain), then 3 (loopback), for one cycle each. It shows code 0 at all other times. `gain_mode` carries chain c at bits [2c+1:2c].
- R4: A residual (5 bits, chain c at bits [5c+4:5c] of `res_i` and of `res_q`) is in window when it lies between 7 and 24 inclusive. A chain fails a pass if any of its six samples (I and Q in each of the three gain modes) is out of window.
- R5: A chain that is not yet finished, fails a pass and has a range below 3 increments its range by exactly one and is tried again.
- R6: A chain that passes is finished. A chain that fails at range 3 is finished with its range left at 3. A finished chain's range does not change again within the operation.
- R7: Passes repeat until all chains are finished. The block then raises `done` for exactly one cycle, so one operation issues 1 + P requests, where P is the largest number of passes any chain needs.
- R8: `cal_busy` is sampled from the cycle after a request. If it is seen low within the first `TIMEOUT_CYC` cycles of the wait, the sequence proceeds; busy falling in the last of those cycles still counts as completion. Otherwise `fail` pulses for one cycle, `done` does not pulse, the block returns to idle, and the ranges keep the values they held when the wait timed out.
- R9: A start asserted while an operation is in progress is ignored: it neither restarts the sequence nor reloads the ranges.
- R10: A synchronous active-low reset returns the block to idle. It drives `done`, `fail`, `cal_req`, `ofs_cal_en`, `gain_mode` and `range_out` to zero and clears all finished flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| cal_busy | input | 1 | Calibration engine busy indication |
| range_init | input | NCH*RANGE_W | Preloaded starting range per chain |
| res_i | input | NCH*RES_W | I residual offset per chain |
| res_q | input | NCH*RES_W | Q residual offset per chain |
| done | output | 1 | One-cycle pulse on successful completion |
| fail | output | 1 | One-cycle pulse on calibration timeout |
| cal_req | output | 1 | One-cycle calibration request |
| ofs_cal_en | output | 1 | Offset calibration enabled for the current request |
| range_out | output | NCH*RANGE_W | Current range per chain |
| gain_mode | output | NCH*2 | Gain-mode field per chain |

## Verification
Two events can land in the same cycle: the engine's busy line falling, and the wait timer reaching its last permitted count. The bench's engine model holds busy for a programmable number of cycles. It is set to exactly one less than the timeout, and then to exactly the timeout, once for the preliminary wait and once for a pass wait. The first setting must still be taken as completion, with the normal final ranges and a done pulse. The second must produce a single fail pulse, no done, and unchanged ranges.

// File: rtl/rxofs_pkg.sv
// Shared types and codes for the receive offset range calibrator.
package rxofs_pkg;

    // Sequencer phases.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_REQ,
        ST_PRE_WAIT,
        ST_PASS_REQ,
        ST_PASS_WAIT,
        ST_SAMPLE,
        ST_EVAL
    } seq_state_t;

    // Gain-mode field codes; the sampling order is HIGH, LOW, LOOP.
    localparam int          GM_W    = 2;
    localparam logic [1:0]  GM_OFF  = 2'd0;
    localparam logic [1:0]  GM_HIGH = 2'd1;
    localparam logic [1:0]  GM_LOW  = 2'd2;
    localparam logic [1:0]  GM_LOOP = 2'd3;

endpackage

// File: rtl/rxofs_wait_timer.sv
// Wait-window timer.
// Counts the cycles spent waiting on the calibration engine and flags the
// last permitted cycle. Assumes TIMEOUT_CYC >= 2. Cleared on every request.
module rxofs_wait_timer #(
    parameter int TIMEOUT_CYC = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Advance while waiting, hold at the last count, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == LAST);

endmodule

// File: rtl/rxofs_window_chk.sv
// Residual window comparator for one chain.
// Flags a chain when either its I or its Q residual lies outside the
// inclusive window [WIN_LO, WIN_HI]. Purely combinational.
module rxofs_window_chk #(
    parameter int RES_W  = 5,
    parameter int WIN_LO = 7,
    parameter int WIN_HI = 24
) (
    input  logic [RES_W-1:0] res_i,
    input  logic [RES_W-1:0] res_q,
    output logic             out_of_win
);
    localparam logic [RES_W-1:0] LO_V = RES_W'(WIN_LO);
    localparam logic [RES_W-1:0] HI_V = RES_W'(WIN_HI);

    // Compare both residuals against both bounds.
    always_comb begin
        out_of_win = (res_i < LO_V) || (res_i > HI_V) ||
                     (res_q < LO_V) || (res_q > HI_V);
    end

endmodule

// File: rtl/rxofs_chain_ctl.sv
// Per-chain range search state.
// Holds the chain's range, a sticky pass-failure flag collected over the
// three gain-mode samples, and the finished flag. Assumes the controller
// clears the failure flag before sampling and evaluates once per pass.
module rxofs_chain_ctl #(
    parameter int RANGE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [RANGE_W-1:0] init,
    input  logic               clr_acc,
    input  logic               smp_en,
    input  logic               out_of_win,
    input  logic               eval_en,
    output logic [RANGE_W-1:0] range_q,
    output logic               done_nxt
);
    localparam logic [RANGE_W-1:0] RMAX = '1;

    logic fin_q;
    logic bad_q;
    logic at_top;

    assign at_top   = (range_q == RMAX);
    assign done_nxt = fin_q || (eval_en && (!bad_q || at_top));

    // Range register: preload on start, step up on a failed pass below top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            range_q <= '0;
        end else if (load) begin
            range_q <= init;
        end else if (eval_en && !fin_q && bad_q && !at_top) begin
            range_q <= range_q + 1'b1;
        end
    end

    // Finished flag: cleared on start, set on pass or saturated failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q <= 1'b0;
        end else if (load) begin
            fin_q <= 1'b0;
        end else if (eval_en) begin
            fin_q <= done_nxt;
        end
    end

    // Sticky failure collector across the three gain-mode samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_q <= 1'b0;
        end else if (clr_acc) begin
            bad_q <= 1'b0;
        end else if (smp_en && out_of_win) begin
            bad_q <= 1'b1;
        end
    end

endmodule

// File: rtl/rx_dco_range_cal.sv
// Receive DC offset range calibrator (top).
// Runs one calibration with offset correction off, then repeated passes:
// request a calibration, wait for the engine, sample residuals in three
// gain modes, and step each failing chain's range. Assumes the engine
// raises cal_busy on the cycle after cal_req and holds it until finished.
module rx_dco_range_cal #(
    parameter int NCH         = 3,
    parameter int RANGE_W     = 2,
    parameter int RES_W       = 5,
    parameter int WIN_LO      = 7,
    parameter int WIN_HI      = 24,
    parameter int CLK_KHZ     = 125000,
    parameter int TIMEOUT_CYC = CLK_KHZ
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     cal_busy,
    input  logic [NCH*RANGE_W-1:0]   range_init,
    input  logic [NCH*RES_W-1:0]     res_i,
    input  logic [NCH*RES_W-1:0]     res_q,
    output logic                     done,
    output logic                     fail,
    output logic                     cal_req,
    output logic                     ofs_cal_en,
    output logic [NCH*RANGE_W-1:0]   range_out,
    output logic [NCH*2-1:0]         gain_mode
);
    import rxofs_pkg::*;

    seq_state_t     st_q, st_d;
    logic [GM_W-1:0] gain_q;
    logic           done_q, fail_q;
    logic           in_req, in_wait, load_c, tmo, all_done;
    logic [NCH-1:0] oow, done_nxt;

    assign in_req   = (st_q == ST_PRE_REQ)  || (st_q == ST_PASS_REQ);
    assign in_wait  = (st_q == ST_PRE_WAIT) || (st_q == ST_PASS_WAIT);
    assign load_c   = (st_q == ST_IDLE) && start;
    assign all_done = &done_nxt;

    rxofs_wait_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (in_req),
        .run     (in_wait),
        .expired (tmo)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chain
        rxofs_window_chk #(
            .RES_W  (RES_W),
            .WIN_LO (WIN_LO),
            .WIN_HI (WIN_HI)
        ) u_win (
            .res_i      (res_i[c*RES_W +: RES_W]),
            .res_q      (res_q[c*RES_W +: RES_W]),
            .out_of_win (oow[c])
        );

        rxofs_chain_ctl #(
            .RANGE_W (RANGE_W)
        ) u_ctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load_c),
            .init       (range_init[c*RANGE_W +: RANGE_W]),
            .clr_acc    (st_q == ST_PASS_REQ),
            .smp_en     (st_q == ST_SAMPLE),
            .out_of_win (oow[c]),
            .eval_en    (st_q == ST_EVAL),
            .range_q    (range_out[c*RANGE_W +: RANGE_W]),
            .done_nxt   (done_nxt[c])
        );

        assign gain_mode[c*GM_W +: GM_W] = gain_q;
    end

    // Next-phase selection; engine completion outranks the timeout.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:      if (start) st_d = ST_PRE_REQ;
            ST_PRE_REQ:   st_d = ST_PRE_WAIT;
            ST_PRE_WAIT:  if (!cal_busy) st_d = ST_PASS_REQ;
                          else if (tmo) st_d = ST_IDLE;
            ST_PASS_REQ:  st_d = ST_PASS_WAIT;
            ST_PASS_WAIT: if (!cal_busy) st_d = ST_SAMPLE;
                          else if (tmo) st_d = ST_IDLE;
            ST_SAMPLE:    if (gain_q == GM_LOOP) st_d = ST_EVAL;
            ST_EVAL:      st_d = all_done ? ST_IDLE : ST_PASS_REQ;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Gain-mode sweep: high, low, loopback, then back to off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= GM_OFF;
        end else if ((st_q == ST_PASS_WAIT) && !cal_busy) begin
            gain_q <= GM_HIGH;
        end else if (st_q == ST_SAMPLE) begin
            gain_q <= (gain_q == GM_LOOP) ? GM_OFF : gain_q + 1'b1;
        end
    end

    // Completion and abort pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= (st_q == ST_EVAL) && all_done;
            fail_q <= in_wait && cal_busy && tmo;
        end
    end

    assign done       = done_q;
    assign fail       = fail_q;
    assign cal_req    = in_req;
    assign ofs_cal_en = (st_q == ST_PASS_REQ) || (st_q == ST_PASS_WAIT) ||
                        (st_q == ST_SAMPLE)   || (st_q == ST_EVAL);

endmodule

// File: rtl/rxofs_checker.sv
// Protocol and progress checks for the offset range calibrator.
// Observes only the top module's ports.
module rxofs_checker #(
    parameter int NCH = 3,
    parameter int RW  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                cal_busy,
    input logic                done,
    input logic                fail,
    input logic                cal_req,
    input logic                ofs_cal_en,
    input logic [NCH*RW-1:0]   range_out,
    input logic [NCH*2-1:0]    gain_mode
);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_req |=> !cal_req);

    // R8
    done_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R8
    fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(cal_busy));

    // R3
    gain_hi_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_mode[1:0] == 2'd1) |=> (gain_mode[1:0] == 2'd2));

    // R3
    gain_lo_lb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_mode[1:0] == 2'd2) |=> (gain_mode[1:0] == 2'd3));

    // R3
    gain_lb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_mode[1:0] == 2'd3) |=> (gain_mode[1:0] == 2'd0));

    // R2
    gain_in_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_mode[1:0] != 2'd0) |-> ofs_cal_en);

    for (genvar c = 0; c < NCH; c++) begin : g_rng
        // R5
        range_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !start |=> ((range_out[c*RW +: RW] == $past(range_out[c*RW +: RW])) ||
                        ({1'b0, range_out[c*RW +: RW]} ==
                         {1'b0, $past(range_out[c*RW +: RW])} + 1'b1)));
    end

endmodule

bind rx_dco_range_cal rxofs_checker #(
    .NCH (NCH),
    .RW  (RANGE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cal_busy   (cal_busy),
    .done       (done),
    .fail       (fail),
    .cal_req    (cal_req),
    .ofs_cal_en (ofs_cal_en),
    .range_out  (range_out),
    .gain_mode  (gain_mode)
);

// File: tb/rx_dco_range_cal_bench.sv
`timescale 1ns/1ps
module rx_dco_range_cal_bench;
    localparam int NCH = 3;
    localparam int RW  = 2;
    localparam int RSW = 5;
    localparam int TMO = 20;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, start, cal_busy, done, fail, cal_req, ofs_cal_en;
    logic [NCH*RW-1:0]  range_init, range_out;
    logic [NCH*RSW-1:0] res_i, res_q;
    logic [NCH*2-1:0]   gain_mode;

    rx_dco_range_cal #(.NCH(NCH), .RANGE_W(RW), .RES_W(RSW), .TIMEOUT_CYC(TMO))
    u_rx_dco_range_cal (
        .clk(clk), .rst_n(rst_n), .start(start), .cal_busy(cal_busy),
        .range_init(range_init), .res_i(res_i), .res_q(res_q),
        .done(done), .fail(fail), .cal_req(cal_req), .ofs_cal_en(ofs_cal_en),
        .range_out(range_out), .gain_mode(gain_mode)
    );

    // Engine and front-end model settings.
    int g_thr [NCH];
    int sel_pos, pre_len, pass_len;
    logic [RSW-1:0] bad_v, good_v;
    int cur_len, eng_cnt;
    assign cur_len = ofs_cal_en ? pass_len : pre_len;

    // Engine: busy for cur_len cycles starting after a request.
    always @(posedge clk) begin
        if (!rst_n) begin
            cal_busy <= 1'b0;
            eng_cnt  <= 0;
        end else if (cal_req) begin
            cal_busy <= (cur_len > 0);
            eng_cnt  <= cur_len;
        end else if (eng_cnt > 1) begin
            eng_cnt <= eng_cnt - 1;
        end else begin
            cal_busy <= 1'b0;
            eng_cnt  <= 0;
        end
    end

    // Front end: one selected sample is bad while range is below threshold.
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            int gm, rg, pos;
            gm  = int'(gain_mode[c*2 +: 2]);
            rg  = int'(range_out[c*RW +: RW]);
            pos = (gm - 1) * 2;
            res_i[c*RSW +: RSW] = (gm != 0 && rg < g_thr[c] && sel_pos == pos)     ? bad_v : good_v;
            res_q[c*RSW +: RSW] = (gm != 0 && rg < g_thr[c] && sel_pos == pos + 1) ? bad_v : good_v;
        end
    end

    int n_chk = 0, n_bad = 0;
    int n_req, n_pre, n_done, n_fail, gi, gseq;
    bit fin;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Start one operation and observe it until done/fail plus a tail.
    task automatic do_run(input logic [NCH*RW-1:0] init, input int inj);
        n_req = 0; n_pre = 0; n_done = 0; n_fail = 0; gi = 0; gseq = 0; fin = 0;
        @(negedge clk);
        range_init = init;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3000 && !fin; i++) begin
            if (cal_req) begin
                n_req++;
                if (!ofs_cal_en) n_pre++;
            end
            if (gain_mode[1:0] != 2'd0 && gi < 3) begin
                gseq = gseq * 10 + int'(gain_mode[1:0]);
                gi++;
            end
            if (done) n_done++;
            if (fail) n_fail++;
            if (done || fail) fin = 1;
            if (i == inj) begin
                start = 1'b1;
                range_init = ~init;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (done) n_done++;
            if (fail) n_fail++;
            @(negedge clk);
        end
        chk(fin, "R7", "operation finished", int'(fin), 1);
    endtask

    // Expected results for a run that completes normally.
    task automatic judge(input logic [NCH*RW-1:0] init);
        int p, ge, r0, fr;
        bit boow;
        logic [NCH*RW-1:0] exp_r;
        p = 0;
        boow = (bad_v < 7) || (bad_v > 24);
        for (int c = 0; c < NCH; c++) begin
            r0 = int'(init[c*RW +: RW]);
            ge = boow ? ((g_thr[c] > 3) ? 3 : g_thr[c]) : 0;
            fr = (ge > r0) ? ge : r0;
            exp_r[c*RW +: RW] = RW'(fr);
            if (((ge > r0) ? ge - r0 : 0) + 1 > p) p = ((ge > r0) ? ge - r0 : 0) + 1;
        end
        chk(n_done == 1, "R7", "done pulse count", n_done, 1);
        chk(n_fail == 0, "R8", "fail pulse count", n_fail, 0);
        chk(n_pre == 1, "R2", "requests with offset cal off", n_pre, 1);
        chk(n_req == 1 + p, "R7", "request count", n_req, 1 + p);
        chk(range_out == exp_r, "R5/R6", "final ranges", int'(range_out), int'(exp_r));
        chk(gseq == 123, "R3", "gain mode order", gseq, 123);
    endtask

    task automatic set_thr(input int a, input int b, input int c);
        g_thr[0] = a; g_thr[1] = b; g_thr[2] = c;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [NCH*RW-1:0] held;
        rst_n = 1'b0; start = 1'b0; range_init = '0;
        set_thr(0, 0, 0); sel_pos = 0; bad_v = 5'd0; good_v = 5'd15;
        pre_len = 3; pass_len = 5;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(done == 0 && fail == 0, "R10", "pulses in reset", int'({done, fail}), 0);
        chk(cal_req == 0 && ofs_cal_en == 0, "R10", "request in reset", int'({cal_req, ofs_cal_en}), 0);
        chk(gain_mode == 0 && range_out == 0, "R10", "gain/range in reset",
            int'({gain_mode, range_out}), 0);
        rst_n = 1'b1;

        // Sweep starting range and threshold per chain (R4 R5 R6 R7).
        for (int r = 0; r < 4; r++) begin
            for (int g = 0; g < 5; g++) begin
                logic [NCH*RW-1:0] init;
                init = {RW'((r + 3) % 4), RW'((r + 1) % 4), RW'(r)};
                set_thr(g, (g + 2) % 5, (g + 4) % 5);
                sel_pos = (r * 5 + g) % 6;
                bad_v = ((r + g) % 2 == 1) ? 5'd31 : 5'd0;
                do_run(init, -1);
                judge(init);
            end
        end

        // R4 window edges on the bad sample.
        for (int k = 0; k < 4; k++) begin
            int bv;
            bv = (k == 0) ? 6 : (k == 1) ? 7 : (k == 2) ? 24 : 25;
            bad_v = RSW'(bv); set_thr(4, 4, 4); sel_pos = 2 + k;
            do_run('0, -1);
            judge('0);
            chk(int'(range_out[1:0]) == ((bv == 7 || bv == 24) ? 0 : 3), "R4",
                "edge residual range", int'(range_out[1:0]), (bv == 7 || bv == 24) ? 0 : 3);
        end
        // R4 edge values on all other samples.
        bad_v = 5'd0; set_thr(1, 2, 3);
        good_v = 5'd7;  sel_pos = 5; do_run(6'b00_01_00, -1); judge(6'b00_01_00);
        good_v = 5'd24; sel_pos = 1; do_run(6'b10_00_01, -1); judge(6'b10_00_01);
        good_v = 5'd15;

        // R8 completion in the last permitted cycle of each wait.
        bad_v = 5'd31; sel_pos = 0; set_thr(2, 1, 0);
        pre_len = TMO - 1; pass_len = TMO - 1;
        do_run('0, -1); judge('0);
        pre_len = 0; pass_len = 0;
        do_run('0, -1); judge('0);
        // R8 timeout in the preliminary wait.
        pre_len = TMO; pass_len = 5;
        do_run(6'b01_10_11, -1);
        chk(n_fail == 1, "R8", "fail pulse on first wait", n_fail, 1);
        chk(n_done == 0, "R8", "no done on abort", n_done, 0);
        chk(n_req == 1, "R8", "requests before abort", n_req, 1);
        chk(range_out == 6'b01_10_11, "R8", "ranges after abort", int'(range_out), 'b011011);
        // R8 timeout in the first pass wait.
        pre_len = 2; pass_len = TMO;
        do_run(6'b00_01_00, -1);
        chk(n_fail == 1, "R8", "fail pulse on pass wait", n_fail, 1);
        chk(n_done == 0, "R8", "no done on pass abort", n_done, 0);
        chk(n_req == 2, "R8", "requests before pass abort", n_req, 2);
        chk(range_out == 6'b00_01_00, "R8", "ranges after pass abort", int'(range_out), 'b000100);

        // R9 start while busy is ignored.
        pre_len = 3; pass_len = 5; set_thr(3, 1, 2);
        do_run('0, 8);  judge('0);
        chk(range_out == 6'b10_01_11, "R9", "ranges after mid-run start", int'(range_out), 'b100111);
        do_run('0, 25); judge('0);

        // R1 hold after completion, preload ignored while idle.
        held = range_out;
        range_init = ~held;
        repeat (10) @(negedge clk);
        chk(range_out == held, "R1", "range held while idle", int'(range_out), int'(held));

        // R10 reset in the middle of an operation.
        set_thr(4, 4, 4);
        @(negedge clk); range_init = 6'b01_01_01; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(range_out == 0 && gain_mode == 0, "R10", "range/gain after reset",
            int'({range_out, gain_mode}), 0);
        chk(cal_req == 0 && ofs_cal_en == 0, "R10", "request after reset",
            int'({cal_req, ofs_cal_en}), 0);
        rst_n = 1'b1;
        n_req = 0;
        for (int i = 0; i < 30; i++) begin
            if (cal_req) n_req++;
            @(negedge clk);
        end
        chk(n_req == 0, "R10", "idle after reset", n_req, 0);
        set_thr(1, 0, 2);
        do_run(6'b00_00_00, -1); judge('0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule